// File: doc/BRIEF.md
# DRAM Single-Bank Read Command Sequencer

This block turns read requests into timed DRAM commands for one bank. Each request carries a row and a column address. The block issues row-open (ACTIVATE), column read (READ) and row-close (PRECHARGE) commands on a registered command bus. It leaves the last row open after every access. The next request is then handled in one of three ways. A row hit issues READ only. A request with no row open issues ACTIVATE then READ. A request to a different row (a conflict) issues PRECHARGE, ACTIVATE and READ. A data-valid strobe is raised once the read latency has run out.

Five timing values set the gaps between commands, and software may change them. They are the read latency, the open-to-read gap, the close-to-open gap, the minimum time a row stays open, and the command rate of one or two cycles from chip select to the first command. The values are loaded only while the sequencer is idle. A programmed zero is treated as one cycle. The block issues each command at the earliest cycle that every gap allows. Every other cycle carries a no-operation code.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_cs` is 0, `cmd_op` is NOP and `rd_valid` is 0. No row is open, so the first request takes the empty-row path.
- R2: When a request is accepted at clock edge E, `cmd_cs` is 1 from edge E onward. The first command appears at edge E+C, where C is 1 when `cfg_cr2`=0 and 2 when `cfg_cr2`=1. Until then the bus carries NOP. `cmd_cs` stays 1 through the cycle of the READ and is 0 in the cycle after it.
- R3: A request to the open row issues only READ, at edge E+C, with `cmd_addr` equal to the column, zero-extended.
- R4: A request with no row open issues ACTIVATE at E+C, with `cmd_addr` equal to the row. It then issues READ exactly tRCD cycles after the ACTIVATE.
- R5: A request to a row other than the open one issues PRECHARGE. ACTIVATE follows exactly tRP cycles later, and READ exactly tRCD cycles after that.
- R6: PRECHARGE is issued at the later of E+C and A+tRAS, where A is the edge of the last ACTIVATE. A conflict that arrives early is therefore held back.
- R7: `rd_valid` is a one-cycle pulse exactly CL cycles after the READ. `req_ready` returns to 1 in the same cycle.
- R8: `req_ready` is 0 from the cycle after acceptance until the cycle of the `rd_valid` pulse.
- R9: A `cfg_load` pulse while `req_ready` is 0 has no effect. Later sequences use the earlier values.
- R10: A timing field loaded as 0 behaves as 1 cycle.
- R11: Command encoding is NOP=00, ACTIVATE=01, READ=10, PRECHARGE=11. At most one command is issued per cycle, and a command other than NOP appears only while `cmd_cs` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load the timing fields (only while idle) |
| cfg_cl | input | TW | Read latency CL |
| cfg_trcd | input | TW | Gap from ACTIVATE to READ |
| cfg_trp | input | TW | Gap from PRECHARGE to ACTIVATE |
| cfg_tras | input | TW | Gap from ACTIVATE to PRECHARGE |
| cfg_cr2 | input | 1 | Command rate: 0 gives 1 cycle, 1 gives 2 cycles |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_row | input | ROW_W | Row address of request |
| req_col | input | COL_W | Column address of request (COL_W ≤ ROW_W) |
| cmd_cs | output | 1 | Chip select |
| cmd_op | output | 2 | Command code |
| cmd_addr | output | ROW_W | Row for ACTIVATE, column for READ, else 0 |
| rd_valid | output | 1 | Read data valid strobe |

## Verification
The hardest case to reach is a conflict whose PRECHARGE is held back by the open-row minimum. It needs a short command rate, a short read latency and a long tRAS. The stimulus reaches it by sweeping small values of CL, tRCD, tRP and command rate, with tRAS derived arithmetically so that it often exceeds the hit latency. Each sweep point runs the sequence empty, hit, conflict, conflict back, hit. A configuration load is poked into the middle of a busy sequence so that the next sequence shows whether the load was ignored.

// File: rtl/dram_seq_pkg.sv
// Shared types for the DRAM bank sequencer.
package dram_seq_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_ACT = 2'b01,
        OP_RD  = 2'b10,
        OP_PRE = 2'b11
    } dram_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_TRP,
        ST_TRCD,
        ST_CL
    } seq_st_e;

    typedef enum logic [1:0] {
        PATH_HIT,
        PATH_EMPTY,
        PATH_CONFLICT
    } path_e;
endpackage

// File: rtl/dram_timing_cfg.sv
// Timing field store. Holds CL, tRCD, tRP, tRAS and the command rate.
// A zero field is stored as one. While load_en is high the outputs show the
// incoming values, so a sequence that starts on the loading edge uses them.
// Assumes load_en is only raised while the sequencer is idle.
module dram_timing_cfg #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [TW-1:0] cl_in,
    input  logic [TW-1:0] trcd_in,
    input  logic [TW-1:0] trp_in,
    input  logic [TW-1:0] tras_in,
    input  logic          cr2_in,
    output logic [TW-1:0] cl,
    output logic [TW-1:0] trcd,
    output logic [TW-1:0] trp,
    output logic [TW-1:0] tras,
    output logic [1:0]    cr
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cl_q, trcd_q, trp_q, tras_q;
    logic [1:0]    cr_q;

    function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    // Store the clamped fields on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_q   <= ONE;
            trcd_q <= ONE;
            trp_q  <= ONE;
            tras_q <= ONE;
            cr_q   <= 2'd1;
        end else if (load_en) begin
            cl_q   <= at_least_one(cl_in);
            trcd_q <= at_least_one(trcd_in);
            trp_q  <= at_least_one(trp_in);
            tras_q <= at_least_one(tras_in);
            cr_q   <= cr2_in ? 2'd2 : 2'd1;
        end
    end

    // Show the incoming values in the loading cycle, else the stored ones.
    always_comb begin
        cl   = load_en ? at_least_one(cl_in)   : cl_q;
        trcd = load_en ? at_least_one(trcd_in) : trcd_q;
        trp  = load_en ? at_least_one(trp_in)  : trp_q;
        tras = load_en ? at_least_one(tras_in) : tras_q;
        cr   = load_en ? (cr2_in ? 2'd2 : 2'd1) : cr_q;
    end
endmodule

// File: rtl/dram_gap_counter.sv
// Down counter for a minimum command gap. Loading N at edge L makes
// 'expired' true before edge L+N, so an action taken on 'expired' lands
// at least N edges after the load. The counter stops at zero.
module dram_gap_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load, or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - W'(1);
    end

    // The gap is over once one or zero cycles remain.
    assign expired = (cnt <= W'(1));
endmodule

// File: rtl/dram_bank_seq.sv
// Single-bank DRAM read sequencer. It accepts a row/column request, decides
// on hit, empty or conflict against the open row, and issues PRECHARGE,
// ACTIVATE and READ at the earliest legal edges. It then pulses rd_valid
// CL cycles after the READ. Assumes COL_W <= ROW_W (the column is
// zero-extended onto cmd_addr).
module dram_bank_seq
    import dram_seq_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    parameter int TW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [TW-1:0]    cfg_cl,
    input  logic [TW-1:0]    cfg_trcd,
    input  logic [TW-1:0]    cfg_trp,
    input  logic [TW-1:0]    cfg_tras,
    input  logic             cfg_cr2,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             cmd_cs,
    output logic [1:0]       cmd_op,
    output logic [ROW_W-1:0] cmd_addr,
    output logic             rd_valid
);
    localparam int SW = TW + 4;

    seq_st_e          st, st_d;
    path_e            path_q, path_d;
    logic [ROW_W-1:0] row_q, open_row_q;
    logic [COL_W-1:0] col_q;
    logic             open_q;
    dram_op_e         op_q, op_d;
    logic [ROW_W-1:0] addr_d;
    logic             accept, fire, go_act, go_rd, go_pre;
    logic             step_ld, step_exp, ras_exp;
    logic [TW-1:0]    step_val;
    logic [TW-1:0]    cl, trcd, trp, tras;
    logic [1:0]       cr;

    assign req_ready = (st == ST_IDLE);
    assign cmd_op    = op_q;

    dram_timing_cfg #(.TW(TW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load_en(cfg_load && (st == ST_IDLE)),
        .cl_in(cfg_cl), .trcd_in(cfg_trcd), .trp_in(cfg_trp),
        .tras_in(cfg_tras), .cr2_in(cfg_cr2),
        .cl(cl), .trcd(trcd), .trp(trp), .tras(tras), .cr(cr)
    );

    // Gap between consecutive steps of one sequence.
    dram_gap_counter #(.W(TW)) u_step (
        .clk(clk), .rst_n(rst_n), .load(step_ld), .load_val(step_val),
        .expired(step_exp)
    );

    // Minimum open time of the row, started by each ACTIVATE.
    dram_gap_counter #(.W(TW)) u_ras (
        .clk(clk), .rst_n(rst_n), .load(go_act), .load_val(tras),
        .expired(ras_exp)
    );

    // Classify an incoming request against the open row.
    always_comb begin
        if (!open_q)                  path_d = PATH_EMPTY;
        else if (req_row == open_row_q) path_d = PATH_HIT;
        else                          path_d = PATH_CONFLICT;
    end

    // Step decisions: which command goes out this edge and what comes next.
    always_comb begin
        accept = 1'b0;
        fire   = 1'b0;
        go_act = 1'b0;
        go_rd  = 1'b0;
        go_pre = 1'b0;
        unique case (st)
            ST_IDLE: accept = req_valid;
            ST_SEL: if (step_exp) begin
                unique case (path_q)
                    PATH_HIT:      go_rd  = 1'b1;
                    PATH_EMPTY:    go_act = 1'b1;
                    default:       go_pre = ras_exp;
                endcase
            end
            ST_TRP:  go_act = step_exp;
            ST_TRCD: go_rd  = step_exp;
            ST_CL:   fire   = step_exp;
            default: ;
        endcase
    end

    // Command, next state and step-counter load for the chosen step.
    always_comb begin
        st_d     = st;
        op_d     = OP_NOP;
        addr_d   = '0;
        step_ld  = 1'b0;
        step_val = '0;
        if (accept) begin
            st_d     = ST_SEL;
            step_ld  = 1'b1;
            step_val = TW'(cr);
        end else if (go_pre) begin
            st_d     = ST_TRP;
            op_d     = OP_PRE;
            step_ld  = 1'b1;
            step_val = trp;
        end else if (go_act) begin
            st_d     = ST_TRCD;
            op_d     = OP_ACT;
            addr_d   = row_q;
            step_ld  = 1'b1;
            step_val = trcd;
        end else if (go_rd) begin
            st_d     = ST_CL;
            op_d     = OP_RD;
            addr_d   = ROW_W'(col_q);
            step_ld  = 1'b1;
            step_val = cl;
        end else if (fire) begin
            st_d     = ST_IDLE;
        end
    end

    // Sequence state and captured request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            path_q <= PATH_EMPTY;
            row_q  <= '0;
            col_q  <= '0;
        end else begin
            st <= st_d;
            if (accept) begin
                path_q <= path_d;
                row_q  <= req_row;
                col_q  <= req_col;
            end
        end
    end

    // Open-row tracking: set by ACTIVATE, cleared by PRECHARGE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q     <= 1'b0;
            open_row_q <= '0;
        end else if (go_act) begin
            open_q     <= 1'b1;
            open_row_q <= row_q;
        end else if (go_pre) begin
            open_q     <= 1'b0;
        end
    end

    // Registered command bus and data strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_NOP;
            cmd_addr <= '0;
            cmd_cs   <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            op_q     <= op_d;
            cmd_addr <= addr_d;
            rd_valid <= fire;
            if (accept)            cmd_cs <= 1'b1;
            else if (st == ST_CL)  cmd_cs <= 1'b0;
        end
    end

    // Observation of command spacing, used only by the assertions below.
    logic [SW-1:0] since_act, since_pre, since_rd;
    logic [TW-1:0] act_trcd, act_tras, pre_trp, rd_cl;

    // Count cycles since each command and keep the gap that applied to it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= '1;
            since_pre <= '1;
            since_rd  <= '1;
            act_trcd  <= '0;
            act_tras  <= '0;
            pre_trp   <= '0;
            rd_cl     <= '0;
        end else begin
            since_act <= (op_q == OP_ACT) ? SW'(1) : ((since_act == '1) ? since_act : since_act + SW'(1));
            since_pre <= (op_q == OP_PRE) ? SW'(1) : ((since_pre == '1) ? since_pre : since_pre + SW'(1));
            since_rd  <= (op_q == OP_RD)  ? SW'(1) : ((since_rd  == '1) ? since_rd  : since_rd  + SW'(1));
            if (op_q == OP_ACT) begin
                act_trcd <= trcd;
                act_tras <= tras;
            end
            if (op_q == OP_PRE) pre_trp <= trp;
            if (op_q == OP_RD)  rd_cl   <= cl;
        end
    end

    // R11
    cmd_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q != OP_NOP) |-> cmd_cs);
    // R3
    read_row_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_RD) |-> open_q);
    // R4
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_RD) |-> (since_act >= SW'(act_trcd)));
    // R5
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_ACT) |-> (since_pre >= SW'(pre_trp)));
    // R6
    ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_PRE) |-> (since_act >= SW'(act_tras)));
    // R7
    data_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (since_rd == SW'(rd_cl)));
    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/dram_bank_seq_test.sv
module dram_bank_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [3:0]  cfg_cl = '0, cfg_trcd = '0, cfg_trp = '0, cfg_tras = '0;
    logic        cfg_cr2 = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        cmd_cs;
    logic [1:0]  cmd_op;
    logic [13:0] cmd_addr;
    logic        rd_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // Model state
    bit m_open;
    int m_row;
    int m_act;
    int k_cl, k_rcd, k_rp, k_ras, k_cr;
    bit k_zero;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_bank_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_cl(cfg_cl),
        .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_tras(cfg_tras),
        .cfg_cr2(cfg_cr2), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .cmd_cs(cmd_cs),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int one_min(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_open = 1'b0;
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(cmd_cs == 1'b0, "R1 cs", int'(cmd_cs), 0);
        chk(cmd_op == 2'b00, "R1 op", int'(cmd_op), 0);
        chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    endtask

    task automatic load_cfg(input int cl, input int rcd, input int rp, input int ras, input int cr2);
        cfg_load = 1'b1;
        cfg_cl = 4'(cl); cfg_trcd = 4'(rcd); cfg_trp = 4'(rp); cfg_tras = 4'(ras);
        cfg_cr2 = cr2[0];
        @(negedge clk);
        cfg_load = 1'b0;
        k_cl = one_min(cl); k_rcd = one_min(rcd); k_rp = one_min(rp);
        k_ras = one_min(ras); k_cr = cr2 ? 2 : 1;
        k_zero = (cl == 0) || (rcd == 0) || (rp == 0) || (ras == 0);
    endtask

    // Issue one request from a negedge with ready high; returns at a negedge.
    task automatic run_req(input int row, input int col, input bit poke, input string extra);
        int e0, first, x_pre, x_act, x_rd, x_val, x_n;
        int t_pre, t_act, t_rd, t_val, n_cmd, a_act, a_rd, guard;
        bit cs_bad, busy_bad, nocs_cmd, done, rdy_at_val;
        string ptag;
        t_pre = -1; t_act = -1; t_rd = -1; t_val = -1; n_cmd = 0;
        a_act = -1; a_rd = -1; cs_bad = 0; busy_bad = 0; nocs_cmd = 0;
        done = 0; rdy_at_val = 0; guard = 0;
        req_valid = 1'b1; req_row = 14'(row); req_col = 10'(col);
        @(negedge clk);
        e0 = cyc;
        req_valid = 1'b0;
        first = e0 + k_cr;
        x_pre = -1; x_act = -1;
        if (m_open && m_row == row) begin
            ptag = "R3"; x_rd = first; x_n = 1;
        end else if (!m_open) begin
            ptag = "R4"; x_act = first; x_rd = x_act + k_rcd; x_n = 2;
        end else begin
            ptag = "R5";
            x_pre = (first > m_act + k_ras) ? first : m_act + k_ras;
            x_act = x_pre + k_rp; x_rd = x_act + k_rcd; x_n = 3;
        end
        x_val = x_rd + k_cl;
        while (!done && guard < 200) begin
            if (poke && cyc == e0) begin
                cfg_load = 1'b1; cfg_cl = 4'hF; cfg_trcd = 4'hF;
                cfg_trp = 4'hF; cfg_tras = 4'hF; cfg_cr2 = (k_cr == 1);
            end else begin
                cfg_load = 1'b0;
            end
            if (cyc <= x_rd && !cmd_cs) cs_bad = 1;
            if (cyc > x_rd && cmd_cs) cs_bad = 1;
            if (cyc < first && cmd_op != 2'b00) cs_bad = 1;
            if (cmd_op != 2'b00) begin
                n_cmd++;
                if (!cmd_cs) nocs_cmd = 1;
                if (cmd_op == 2'b01) begin t_act = cyc; a_act = int'(cmd_addr); end
                if (cmd_op == 2'b10) begin t_rd = cyc; a_rd = int'(cmd_addr); end
                if (cmd_op == 2'b11) t_pre = cyc;
            end
            if (rd_valid) begin
                t_val = cyc; rdy_at_val = req_ready; done = 1;
            end else begin
                if (req_ready) busy_bad = 1;
                @(negedge clk);
                guard++;
            end
        end
        cfg_load = 1'b0;
        if (x_act >= 0) begin
            m_act = x_act; m_open = 1; m_row = row;
        end
        chk(t_val == x_val, {ptag, " R7 data valid time", extra, k_zero ? " R10" : ""}, t_val, x_val);
        chk(t_rd == x_rd, {ptag, " READ time"}, t_rd, x_rd);
        chk(a_rd == col, {ptag, " READ column"}, a_rd, col);
        chk(n_cmd == x_n, "R11 command count", n_cmd, x_n);
        chk(!nocs_cmd, "R11 command without cs", int'(nocs_cmd), 0);
        chk(!cs_bad, "R2 cs window / first command", int'(cs_bad), 0);
        chk(!busy_bad && rdy_at_val, "R8 ready while busy", int'(busy_bad), 0);
        if (x_act >= 0) begin
            chk(t_act == x_act, {ptag, " ACTIVATE time"}, t_act, x_act);
            chk(a_act == row, {ptag, " ACTIVATE row"}, a_act, row);
        end
        if (x_pre >= 0)
            chk(t_pre == x_pre, "R6 PRECHARGE time", t_pre, x_pre);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R7 strobe width", int'(rd_valid), 0);
        chk(req_ready == 1'b1, "R7 ready after strobe", int'(req_ready), 1);
    endtask

    task automatic run_config(input int cl, input int rcd, input int rp, input int ras, input int cr2, input int tag);
        int ra, rb;
        ra = (tag * 37) % 16384;
        rb = (ra + 1 + tag) % 16384;
        do_reset();
        load_cfg(cl, rcd, rp, ras, cr2);
        run_req(ra, tag % 1024, 1'b0, " R1 empty after reset");
        run_req(ra, (tag + 5) % 1024, 1'b0, "");
        run_req(rb, 1023, 1'b1, "");
        run_req(ra, 0, 1'b0, " R9 after ignored load");
        run_req(ra, 77, 1'b0, " R9");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int idx;
        idx = 0;
        @(negedge clk);
        for (int cl = 0; cl < 4; cl++)
            for (int rcd = 0; rcd < 4; rcd++)
                for (int rp = 0; rp < 3; rp++)
                    for (int cr = 0; cr < 2; cr++) begin
                        run_config(cl, rcd, rp, (cl * 5 + rcd * 3 + rp * 7 + cr * 4) % 16, cr, idx);
                        idx++;
                    end
        run_config(15, 15, 15, 15, 1, idx + 1);
        run_config(1, 1, 1, 15, 0, idx + 2);
        run_config(0, 0, 0, 0, 0, idx + 3);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule